// File: doc/BRIEF.md
# Double-to-Single Store Narrowing Converter

This block turns a 64-bit double-precision register image into the 32-bit single-precision word that a store-single operation writes to memory. It does not round. Each input falls into one of three classes. Normal values, zeros, infinities, NaNs and values too large for single precision all take a direct bit-copy path. Values whose magnitude lies in the single-precision subnormal range are denormalized by a right shift. Values smaller than the smallest single subnormal collapse to a signed zero.

A word is presented with `in_valid`. The converted word appears one clock later on `out_word`, qualified by `out_valid`. Words can be accepted on every cycle, and the output register holds its last value while no new word arrives.

Top module: `f64_store_narrow`

## Requirements
- R1: Output bit 31 always equals input bit 63 (the sign).
- R2: Let the unbiased exponent be input bits 62..52 minus 1023. When it is greater than -127, the output is {in[63], in[62], in[58:52], in[51:29]}. This covers normals, infinities and NaNs. Out-of-range magnitudes such as the largest finite double are not saturated.
- R3: When input bits 62..0 are all zero, the copy path of R2 applies, so +0 gives 0x00000000 and -0 gives 0x80000000.
- R4: Input bits 28..0 never affect the output. The conversion truncates.
- R5: When the unbiased exponent is in -149..-127, output bits 30..23 are zero. Output bits 22..0 are {1, in[51:29]} shifted right by (-126 - exponent), a shift of 1 to 23. So exponent -127 with a zero fraction gives 0x00400000, and exponent -149 gives 0x00000001.
- R6: When the input is nonzero and the unbiased exponent is below -149, the output is the sign followed by 31 zero bits. This includes double subnormals.
- R7: `out_valid` equals `in_valid` delayed by exactly one clock. A synchronous active-high reset clears `out_valid` and `out_word`.
- R8: While `in_valid` is low, `out_word` keeps its previous value and `out_valid` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 64 | Double-precision register image |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_word | output | 32 | Single-precision memory word |

## Verification
In a single cycle the register captures a new conversion while it presents the previous one. Consecutive conversions can also take different paths, for example a copy-path word followed by a denormalized one or a tiny one. The bench streams words with no gaps, so the classification of each word is applied while the previous result is on the port.

Each result is judged one cycle after its input against an arithmetic model built from the rules. The sweep covers every biased exponent with both signs and several fractions. Literal expectations pin the boundary exponents and the special values. Idle gaps with changed data confirm that the held word survives.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

    localparam int DBL_W       = 64;
    localparam int SGL_W       = 32;
    localparam int DBL_EXP_W   = 11;
    localparam int DBL_FRAC_W  = 52;
    localparam int SGL_EXP_W   = 8;
    localparam int SGL_FRAC_W  = 23;
    localparam int DBL_BIAS    = 1023;
    localparam int SGL_MIN_NRM = -126;
    localparam int SGL_MIN_SUB = -149;

    // fraction bits dropped by truncation
    localparam int DROP_W  = DBL_FRAC_W - SGL_FRAC_W;
    localparam int SIG_W   = SGL_FRAC_W + 1;
    localparam int SHAMT_W = $clog2(SIG_W + 1);

    // biased double exponent thresholds
    localparam logic [DBL_EXP_W-1:0] COPY_MIN_B   = DBL_EXP_W'(DBL_BIAS + SGL_MIN_NRM);
    localparam logic [DBL_EXP_W-1:0] DENORM_MIN_B = DBL_EXP_W'(DBL_BIAS + SGL_MIN_SUB);

    typedef enum logic [1:0] {
        PATH_COPY   = 2'd0,
        PATH_DENORM = 2'd1,
        PATH_TINY   = 2'd2
    } path_e;

    typedef struct packed {
        logic                 sign;
        path_e                path;
        logic [SGL_W-2:0]     copy_body;
        logic [SIG_W-1:0]     sig;
        logic [SHAMT_W-1:0]   shamt;
    } cls_t;

    // exponent MSB, low exponent bits, upper fraction bits
    function automatic logic [SGL_W-2:0] copy_body_f(input logic [DBL_W-1:0] d);
        return {d[DBL_W-2],
                d[DBL_FRAC_W+SGL_EXP_W-2:DBL_FRAC_W],
                d[DBL_FRAC_W-1:DROP_W]};
    endfunction

endpackage

// File: rtl/narrow_classify.sv
module narrow_classify
    import narrow_pkg::*;
(
    input  logic [DBL_W-1:0] d,
    output cls_t             cls
);
    logic [DBL_EXP_W-1:0] biased;
    logic                 mag_zero;

    assign biased   = d[DBL_W-2:DBL_FRAC_W];
    assign mag_zero = (d[DBL_W-2:0] == '0);

    always_comb begin
        cls.sign      = d[DBL_W-1];
        cls.copy_body = copy_body_f(d);
        cls.sig       = {1'b1, d[DBL_FRAC_W-1:DROP_W]};
        cls.shamt     = SHAMT_W'(COPY_MIN_B - biased);
        if (mag_zero || (biased >= COPY_MIN_B))
            cls.path = PATH_COPY;
        else if (biased >= DENORM_MIN_B)
            cls.path = PATH_DENORM;
        else
            cls.path = PATH_TINY;
    end
endmodule

// File: rtl/narrow_denorm.sv
module narrow_denorm
    import narrow_pkg::*;
(
    input  logic [SIG_W-1:0]      sig,
    input  logic [SHAMT_W-1:0]    shamt,
    output logic [SGL_FRAC_W-1:0] frac
);
    logic [SIG_W-1:0] stg [0:SHAMT_W];
    logic             msb_unused;

    assign stg[0] = sig;

    // logarithmic right shifter, one stage per shift-amount bit
    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        assign stg[i+1] = shamt[i] ? (stg[i] >> (1 << i)) : stg[i];
    end

    assign frac       = stg[SHAMT_W][SGL_FRAC_W-1:0];
    assign msb_unused = stg[SHAMT_W][SIG_W-1];
endmodule

// File: rtl/f64_store_narrow.sv
module f64_store_narrow
    import narrow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DBL_W-1:0] in_word,
    output logic             out_valid,
    output logic [SGL_W-1:0] out_word
);
    cls_t                  cls;
    logic [SGL_FRAC_W-1:0] den_frac;
    logic [SGL_W-1:0]      next_word;
    logic                  trunc_unused;

    assign trunc_unused = ^in_word[DROP_W-1:0];

    narrow_classify u_cls (
        .d   (in_word),
        .cls (cls)
    );

    narrow_denorm u_den (
        .sig   (cls.sig),
        .shamt (cls.shamt),
        .frac  (den_frac)
    );

    always_comb begin
        unique case (cls.path)
            PATH_COPY:   next_word = {cls.sign, cls.copy_body};
            PATH_DENORM: next_word = {cls.sign, {SGL_EXP_W{1'b0}}, den_frac};
            default:     next_word = {cls.sign, {(SGL_W-1){1'b0}}};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_word <= next_word;
        end
    end

    // R7: valid tracks input one cycle later
    a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r7_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8: held word while idle
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));
    // R1: sign carried through
    a_r1_sign: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_word[SGL_W-1] == $past(in_word[DBL_W-1])));
    // R5: denormalized results have a zero exponent field
    a_r5_denorm_exp_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls.path == PATH_DENORM) |=> (out_word[SGL_W-2:SGL_FRAC_W] == '0));
    // R6: tiny inputs flush to signed zero
    a_r6_tiny_flush: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls.path == PATH_TINY) |=> (out_word[SGL_W-2:0] == '0));
endmodule

// File: tb/f64_store_narrow_tb_top.sv
`timescale 1ns/1ps
module f64_store_narrow_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_word;
    logic        out_valid;
    logic [31:0] out_word;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    f64_store_narrow dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    function automatic logic [31:0] model(input logic [63:0] v);
        int          e;
        int          sh;
        logic [23:0] s24;
        e = int'(v[62:52]) - 1023;
        if (e > -127 || v[62:0] == 63'd0)
            return {v[63], v[62], v[58:52], v[51:29]};
        else if (e >= -149) begin
            sh  = -126 - e;
            s24 = {1'b1, v[51:29]} >> sh;
            return {v[63], 8'd0, s24[22:0]};
        end
        return {v[63], 31'd0};
    endfunction

    function automatic string req_of(input logic [63:0] v);
        int e;
        e = int'(v[62:52]) - 1023;
        if (v[62:0] == 63'd0) return "R3";
        if (e > -127)         return "R2";
        if (e >= -149)        return "R5";
        return "R6";
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // called at a negedge; drives, waits one cycle, checks
    task automatic run_vec(input logic [63:0] v);
        logic [31:0] e;
        e        = model(v);
        in_valid = 1'b1;
        in_word  = v;
        @(negedge clk);
        chk(out_valid === 1'b1, "R7", {31'd0, out_valid}, 32'd1);
        chk(out_word === e, req_of(v), out_word, e);
        chk(out_word[31] === v[63], "R1", {31'd0, out_word[31]}, {31'd0, v[63]});
    endtask

    task automatic run_lit(input logic [63:0] v, input logic [31:0] e, input string req);
        in_valid = 1'b1;
        in_word  = v;
        @(negedge clk);
        chk(out_word === e, req, out_word, e);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] v;
        logic [31:0] held;
        logic [31:0] a;
        logic [31:0] b;
        logic [51:0] fr [3];
        rst      = 1'b1;
        in_valid = 1'b0;
        in_word  = '0;
        fr[0] = 52'h0;
        fr[1] = 52'hF_FFFF_FFFF_FFFF;
        fr[2] = 52'hA_5A5A_5123_4567;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(out_valid === 1'b0, "R7", {31'd0, out_valid}, 32'd0);
        chk(out_word === 32'd0, "R7", out_word, 32'd0);
        rst = 1'b0;

        // literal boundary and special values
        run_lit(64'h0000_0000_0000_0000, 32'h0000_0000, "R3");
        run_lit(64'h8000_0000_0000_0000, 32'h8000_0000, "R3");
        run_lit(64'h7FF0_0000_0000_0000, 32'h7F80_0000, "R2");
        run_lit(64'hFFF0_0000_0000_0000, 32'hFF80_0000, "R2");
        run_lit(64'h7FF8_0000_0000_0000, 32'h7FC0_0000, "R2");
        run_lit(64'h7FF0_0000_0000_0001, 32'h7F80_0000, "R2");
        run_lit(64'h7FF0_0000_2000_0000, 32'h7F80_0001, "R2");
        run_lit(64'h7FEF_FFFF_FFFF_FFFF, 32'h7F7F_FFFF, "R2");
        run_lit({1'b0, 11'd897, 52'd0}, 32'h0080_0000, "R2");
        run_lit({1'b0, 11'd896, 52'd0}, 32'h0040_0000, "R5");
        run_lit({1'b1, 11'd896, 52'hF_FFFF_E000_0000}, 32'h807F_FFFF, "R5");
        run_lit({1'b0, 11'd874, 52'd0}, 32'h0000_0001, "R5");
        run_lit({1'b0, 11'd873, 52'hF_FFFF_FFFF_FFFF}, 32'h0000_0000, "R6");
        run_lit({1'b1, 11'd0, 52'h0_0000_0000_0001}, 32'h8000_0000, "R6");

        // R4: low 29 bits ignored
        run_lit({1'b0, 11'd1030, 52'h1_2345_6000_0000}, model({1'b0, 11'd1030, 52'h1_2345_6000_0000}), "R4");
        a = out_word;
        run_lit({1'b0, 11'd1030, 52'h1_2345_7FFF_FFFF}, a, "R4");
        run_lit({1'b0, 11'd880, 52'h3_0000_1FFF_FFFF}, model({1'b0, 11'd880, 52'h3_0000_0000_0000}), "R4");

        // R8: idle cycles keep the word
        held     = out_word;
        in_valid = 1'b0;
        in_word  = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        chk(out_valid === 1'b0, "R8", {31'd0, out_valid}, 32'd0);
        chk(out_word === held, "R8", out_word, held);
        in_word = 64'h0;
        @(negedge clk);
        chk(out_word === held, "R8", out_word, held);

        // sweep every biased exponent, both signs, three fractions, back to back
        for (int ex = 0; ex < 2048; ex++) begin
            for (int s = 0; s < 2; s++) begin
                for (int f = 0; f < 3; f++) begin
                    v = {s[0], ex[10:0], fr[f]};
                    run_vec(v);
                end
            end
        end

        // random words with idle gaps between pairs
        for (int r = 0; r < 600; r++) begin
            v = {$urandom, $urandom};
            run_vec(v);
            if (r % 7 == 0) begin
                b        = out_word;
                in_valid = 1'b0;
                in_word  = ~v;
                @(negedge clk);
                chk(out_word === b, "R8", out_word, b);
            end
        end

        // R7: reset mid-stream clears outputs
        in_valid = 1'b1;
        in_word  = 64'hC000_0000_0000_0000;
        rst      = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R7", {31'd0, out_valid}, 32'd0);
        chk(out_word === 32'd0, "R7", out_word, 32'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule